// File: doc/BRIEF.md
# Transport Stream Sync Lock and PID Filter

This block takes a byte-wide transport stream with a per-byte valid strobe and finds packet boundaries by locking onto the 0x47 sync byte at a fixed 188-byte spacing. Lock needs a run of good sync bytes and is dropped only after a run of missing ones, so one damaged packet does not break framing. While locked, each packet that starts with a sync byte is a candidate. Its first eight bytes are packed into a 64-bit word, and a configurable bit slice of that word gives the packet identifier.

The identifier indexes a one-bit-per-identifier table of 8192 bits, held as 1024 bytes and loaded through a byte write port. A set bit lets the packet through and a clear bit drops it. A global enable input, when low, bypasses the table and lets every candidate packet through. The header bytes wait in a small ring buffer until the table answer arrives. After that, the packet either streams to the output with a start-of-packet marker or is removed from the ring. If the valid strobe drops inside a packet, the packet is aborted and an error counter advances.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, out_valid is 0, locked is 0 and err_count is 0.
- R2: locked rises at the sync byte of the 9th consecutive packet whose first byte is 0x47 at 188-byte spacing. A first byte other than 0x47 before lock is reached sends the framer back to hunting, and the run restarts from zero.
- R3: While locked, a packet start lacking 0x47 counts as a miss, and a good sync byte clears the miss count. locked falls at the 9th consecutive miss.
- R4: A packet is a candidate only if locked was already 1 before its sync byte. The first packet that can be forwarded after acquisition is therefore the 10th good one.
- R5: Bytes 0..7 of a packet form a 64-bit word, with byte 0 in bits 63:56. The identifier is word bits [ofs+len-1:ofs], with ofs from cfg_pid_ofs and len from cfg_pid_len, zero-extended and cut to 13 bits.
- R6: The identifier selects table byte id[12:3] and bit id[2:0] within it. A bit of 1 forwards the candidate packet and a bit of 0 discards it. The table is written through tbl_we, tbl_addr and tbl_wdata.
- R7: With cfg_pid_en at 0, every candidate packet is forwarded whatever the table holds.
- R8: Forwarded packets appear on out_data in their byte order, with out_sop high on byte 0 only. No byte of a discarded packet appears.
- R9: in_valid low at any packet position other than 0 aborts the packet and adds 1 to err_count. Bytes already committed to the output stay. A gap at or before the 9th byte therefore drops the whole packet, and a later gap keeps exactly the bytes sent before it. The next valid byte is treated as a packet start.
- R10: With input packets arriving back to back, the ring buffer never holds more than BUF_DEPTH-1 bytes, and no forwarded byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid strobe |
| in_data | input | 8 | Input stream byte |
| cfg_pid_en | input | 1 | 1: table filtering, 0: pass all candidates |
| cfg_pid_ofs | input | 6 | Low bit of the identifier slice in the header word |
| cfg_pid_len | input | 4 | Width of the identifier slice |
| tbl_we | input | 1 | Table byte write enable |
| tbl_addr | input | 10 | Table byte address |
| tbl_wdata | input | 8 | Table byte data, bit n for identifier 8*addr+n |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output stream byte |
| out_sop | output | 1 | First byte of a forwarded packet |
| locked | output | 1 | Sync lock status |
| err_count | output | 16 | Count of packets aborted by a strobe gap |

## Verification
Two functions can fall in the same cycle, and both cases are provoked on purpose. The table answer for a packet comes back in the cycle after its 8th byte. If the strobe drops exactly then, the abort must win and remove the header already written to the ring. If the strobe drops one byte later, the 9th byte has been committed and must come out. Separately, back-to-back packets make the header of the next packet enter the ring while the previous one is still draining. The byte stream, the start markers and the byte totals are compared with a packet-level model in the bench that tracks lock, slice and table bits.

// File: rtl/ts_pf_pkg.sv
package ts_pf_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam int HDR_BYTES = 8;
endpackage

// File: rtl/ts_sync_framer.sv
module ts_sync_framer
  import ts_pf_pkg::*;
#(
  parameter int PKT_LEN  = 188,
  parameter int LOCK_CNT = 9,
  parameter int DROP_CNT = 9,
  parameter int ERR_W    = 16,
  localparam int POS_W   = $clog2(PKT_LEN),
  localparam int CNT_W   = $clog2((LOCK_CNT > DROP_CNT ? LOCK_CNT : DROP_CNT) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             frame_byte,
  output logic [POS_W-1:0] cur_pos,
  output logic             elig,
  output logic             abort,
  output logic             locked,
  output logic [ERR_W-1:0] err_count
);
  logic             aligned_q, elig_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] good_q, miss_q;
  logic             is_sync, at_start;

  assign is_sync    = (in_data == SYNC_BYTE);
  assign at_start   = !aligned_q || (pos_q == '0);
  assign frame_byte = in_valid && (aligned_q || is_sync);
  assign cur_pos    = aligned_q ? pos_q : '0;
  assign elig       = at_start ? (locked && is_sync) : elig_q;
  assign abort      = !in_valid && aligned_q && (pos_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned_q <= 1'b0;
      elig_q    <= 1'b0;
      pos_q     <= '0;
      good_q    <= '0;
      miss_q    <= '0;
      locked    <= 1'b0;
      err_count <= '0;
    end else if (abort) begin
      pos_q     <= '0;
      elig_q    <= 1'b0;
      err_count <= err_count + ERR_W'(1);
    end else if (in_valid) begin
      if (at_start) begin
        elig_q <= locked && is_sync;
        if (is_sync) begin
          aligned_q <= 1'b1;
          pos_q     <= POS_W'(1);
          miss_q    <= '0;
          if (!locked) begin
            if (good_q == CNT_W'(LOCK_CNT - 1)) begin
              locked <= 1'b1;
              good_q <= '0;
            end else begin
              good_q <= good_q + CNT_W'(1);
            end
          end
        end else if (locked) begin
          if (miss_q == CNT_W'(DROP_CNT - 1)) begin
            locked    <= 1'b0;
            aligned_q <= 1'b0;
            miss_q    <= '0;
            good_q    <= '0;
            pos_q     <= '0;
          end else begin
            miss_q <= miss_q + CNT_W'(1);
            pos_q  <= POS_W'(1);
          end
        end else begin
          aligned_q <= 1'b0;
          good_q    <= '0;
          pos_q     <= '0;
        end
      end else begin
        pos_q <= (pos_q == POS_W'(PKT_LEN - 1)) ? '0 : pos_q + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/ts_pid_lookup.sv
module ts_pid_lookup #(
  parameter int PID_W  = 13,
  localparam int ADDR_W = PID_W - 3,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_wdata,
  input  logic              hdr_en,
  input  logic              hdr_last,
  input  logic [7:0]        data,
  input  logic              cfg_en,
  input  logic [5:0]        cfg_ofs,
  input  logic [3:0]        cfg_len,
  output logic              dec_valid,
  output logic              dec_hit
);
  logic [7:0]       tbl_mem [DEPTH];
  logic [55:0]      hdr_q;
  logic [63:0]      word;
  logic [PID_W-1:0] pid;
  logic [7:0]       row_q;
  logic [2:0]       sel_q;

  assign word = {hdr_q, data};
  assign pid  = PID_W'((word >> cfg_ofs) & ((64'd1 << cfg_len) - 64'd1));

  always_ff @(posedge clk) begin
    if (tbl_we) tbl_mem[tbl_addr] <= tbl_wdata;
  end

  always_ff @(posedge clk) begin
    row_q <= tbl_mem[pid[PID_W-1:3]];
    sel_q <= pid[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q     <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= hdr_en && hdr_last;
      if (hdr_en) hdr_q <= {hdr_q[47:0], data};
    end
  end

  assign dec_hit = !cfg_en || row_q[sel_q];
endmodule

// File: rtl/ts_pkt_ring.sv
module ts_pkt_ring #(
  parameter int BUF_DEPTH = 32,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_en,
  input  logic             in_hdr,
  input  logic             sop,
  input  logic             last,
  input  logic [7:0]       data,
  input  logic             dec_valid,
  input  logic             dec_hit,
  input  logic             abort,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic [LVL_W-1:0] level
);
  logic [8:0]       ring_mem [BUF_DEPTH];
  logic [LVL_W-1:0] wr_q, rd_q, commit_q;
  logic             pass_q, pass_eff, do_wr, has_out;

  assign pass_eff = dec_valid ? dec_hit : pass_q;
  assign do_wr    = byte_en && (in_hdr || pass_eff);
  assign has_out  = (rd_q != commit_q);
  assign level    = wr_q - rd_q;

  always_ff @(posedge clk) begin
    if (do_wr) ring_mem[wr_q[AW-1:0]] <= {sop, data};
  end

  always_ff @(posedge clk) begin
    if (has_out) {out_sop, out_data} <= ring_mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rd_q      <= '0;
      commit_q  <= '0;
      pass_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (abort) begin
        wr_q   <= commit_q;
        pass_q <= 1'b0;
      end else begin
        if (dec_valid && !dec_hit) wr_q <= commit_q;
        else if (do_wr)            wr_q <= wr_q + LVL_W'(1);
        if (pass_eff && (dec_valid || pass_q))
          commit_q <= wr_q + LVL_W'(do_wr);
        if (dec_valid)              pass_q <= dec_hit;
        else if (byte_en && last)   pass_q <= 1'b0;
      end
      out_valid <= has_out;
      if (has_out) rd_q <= rd_q + LVL_W'(1);
    end
  end
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pf_pkg::*;
#(
  parameter int PKT_LEN   = 188,
  parameter int LOCK_CNT  = 9,
  parameter int DROP_CNT  = 9,
  parameter int PID_W     = 13,
  parameter int BUF_DEPTH = 32,
  parameter int ERR_W     = 16,
  localparam int POS_W    = $clog2(PKT_LEN),
  localparam int ADDR_W   = PID_W - 3,
  localparam int LVL_W    = $clog2(BUF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              cfg_pid_en,
  input  logic [5:0]        cfg_pid_ofs,
  input  logic [3:0]        cfg_pid_len,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_wdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              locked,
  output logic [ERR_W-1:0]  err_count
);
  logic             frame_byte, elig, abort, dec_valid, dec_hit;
  logic             cand_byte, in_hdr, hdr_last, pkt_last, pkt_sop;
  logic [POS_W-1:0] cur_pos;
  logic [LVL_W-1:0] ring_level;

  ts_sync_framer #(.PKT_LEN(PKT_LEN), .LOCK_CNT(LOCK_CNT), .DROP_CNT(DROP_CNT),
                   .ERR_W(ERR_W)) u_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .frame_byte(frame_byte), .cur_pos(cur_pos), .elig(elig), .abort(abort),
    .locked(locked), .err_count(err_count));

  assign cand_byte = frame_byte && elig;
  assign in_hdr    = cur_pos < POS_W'(HDR_BYTES);
  assign hdr_last  = cur_pos == POS_W'(HDR_BYTES - 1);
  assign pkt_last  = cur_pos == POS_W'(PKT_LEN - 1);
  assign pkt_sop   = cur_pos == '0;

  ts_pid_lookup #(.PID_W(PID_W)) u_lookup (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .hdr_en(cand_byte && in_hdr), .hdr_last(hdr_last),
    .data(in_data), .cfg_en(cfg_pid_en), .cfg_ofs(cfg_pid_ofs),
    .cfg_len(cfg_pid_len), .dec_valid(dec_valid), .dec_hit(dec_hit));

  ts_pkt_ring #(.BUF_DEPTH(BUF_DEPTH)) u_ring (
    .clk(clk), .rst(rst), .byte_en(cand_byte), .in_hdr(in_hdr), .sop(pkt_sop),
    .last(pkt_last), .data(in_data), .dec_valid(dec_valid), .dec_hit(dec_hit),
    .abort(abort), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .level(ring_level));
endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk
  import ts_pf_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int LVL_W     = 6,
  parameter int BUF_DEPTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             locked,
  input logic [ERR_W-1:0] err_count,
  input logic [LVL_W-1:0] level
);
  // R2: lock is only gained on a sync byte
  p_lock_on_sync_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(in_valid) && $past(in_data) == SYNC_BYTE));

  // R3: lock is only lost on a packet start without sync
  p_drop_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(in_valid) && $past(in_data) != SYNC_BYTE));

  // R9: error count moves by one and only after a strobe gap
  p_err_step_r9: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |->
      (err_count == $past(err_count) + ERR_W'(1) && !$past(in_valid)));

  // R10: ring occupancy stays below its depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    level < LVL_W'(BUF_DEPTH));
endmodule

bind ts_pid_filter ts_pid_filter_chk #(.ERR_W(ERR_W), .LVL_W(LVL_W),
  .BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .locked(locked), .err_count(err_count), .level(ring_level));

// File: tb/ts_pid_filter_test.sv
module ts_pid_filter_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        cfg_pid_en = 1'b1;
  logic [5:0]  cfg_pid_ofs = 6'd40;
  logic [3:0]  cfg_pid_len = 4'd13;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_addr = '0;
  logic [7:0]  tbl_wdata = '0;
  logic        out_valid, out_sop, locked;
  logic [7:0]  out_data;
  logic [15:0] err_count;

  ts_pid_filter uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, bytes_seen = 0, bytes_exp = 0, exp_err = 0;
  bit done = 0;
  logic [8:0] expq[$];
  logic [7:0] tbl_sh [1024];
  bit m_locked = 0;
  int m_good = 0, m_miss = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        bytes_seen++;
        if (expq.size() == 0) chk(0, "R8 unexpected byte", {out_sop, out_data}, -1);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({out_sop, out_data} == e, "R8 stream byte", {out_sop, out_data}, e);
        end
      end
    end
  end

  function automatic logic [7:0] pkt_byte(int idx, logic [12:0] pid, int tag, bit ok);
    logic [7:0] v;
    if (!ok) return (idx == 0) ? 8'h00 : 8'h11;
    if (idx == 0) return 8'h47;
    if (idx == 1) return {3'b010, pid[12:8]};
    if (idx == 2) return pid[7:0];
    v = 8'(tag + idx * 3);
    if (v == 8'h47) v = 8'h48;
    return v;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // gap_at = 0: whole packet; otherwise bytes 0..gap_at-1 then a one-cycle gap
  task automatic send_pkt(input logic [12:0] pid, input int tag, input bit ok, input int gap_at);
    bit elig, hit;
    logic [63:0] w, sl;
    logic [12:0] id;
    int n;
    elig = m_locked && ok;
    if (ok) begin
      m_miss = 0;
      if (!m_locked) begin
        m_good++;
        if (m_good == 9) begin m_locked = 1; m_good = 0; end
      end
    end else if (m_locked) begin
      m_miss++;
      if (m_miss == 9) begin m_locked = 0; m_miss = 0; m_good = 0; end
    end else m_good = 0;
    w = '0;
    for (int i = 0; i < 8; i++) w = {w[55:0], pkt_byte(i, pid, tag, ok)};
    sl = (w >> cfg_pid_ofs) & ((64'd1 << cfg_pid_len) - 64'd1);
    id = sl[12:0];
    hit = !cfg_pid_en || tbl_sh[id[12:3]][id[2:0]];
    n = (gap_at > 0) ? gap_at : 188;
    if (elig && hit && (gap_at == 0 || gap_at >= 9))
      for (int i = 0; i < n; i++) begin
        expq.push_back({(i == 0), pkt_byte(i, pid, tag, ok)});
        bytes_exp++;
      end
    if (gap_at > 0) exp_err++;
    for (int i = 0; i < n; i++) put_byte(pkt_byte(i, pid, tag, ok));
    if (gap_at > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic phase_end(input string tag);
    idle(40);
    chk(expq.size() == 0, tag, expq.size(), 0);
    chk(bytes_seen == bytes_exp, tag, bytes_seen, bytes_exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(locked == 0, "R1 locked", locked, 0);
    chk(err_count == 0, "R1 err_count", err_count, 0);

    // R6: load table with a computed pattern
    for (int a = 0; a < 1024; a++) begin
      tbl_sh[a] = 8'((a * 37 + 11) ^ (a >> 2));
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 10'(a); tbl_wdata = tbl_sh[a];
    end
    @(negedge clk);
    tbl_we = 1'b0;

    // R2: 4 good, 1 bad restarts hunting, then 8 good is not yet lock
    for (int i = 0; i < 4; i++) send_pkt(13'(i * 5), i, 1, 0);
    send_pkt(13'd0, 0, 0, 0);
    for (int i = 0; i < 8; i++) send_pkt(13'(100 + i), i, 1, 0);
    idle(2);
    chk(locked == 0, "R2 locked after 8 good", locked, 0);
    send_pkt(13'd200, 7, 1, 0);
    idle(2);
    chk(locked == 1, "R2 locked after 9th good", locked, 1);
    phase_end("R4 nothing forwarded before lock");
    chk(bytes_seen == 0, "R4 no bytes during acquisition", bytes_seen, 0);

    // R4: the 10th good packet is forwarded (pass-all to guarantee a hit)
    cfg_pid_en = 1'b0;
    send_pkt(13'd300, 9, 1, 0);
    phase_end("R4 first packet after lock");
    chk(bytes_seen == 188, "R4 tenth packet bytes", bytes_seen, 188);
    cfg_pid_en = 1'b1;

    // R5/R6/R8/R10: back-to-back identifier sweep including edge identifiers
    for (int i = 0; i < 60; i++) begin
      logic [12:0] p;
      p = (i == 0) ? 13'd0 : (i == 1) ? 13'h1FFF : 13'((i * 677 + 5) % 8192);
      send_pkt(p, i * 7, 1, 0);
    end
    phase_end("R6 table sweep");
    phase_end("R10 no byte lost back to back");

    // R7: pass-all mode
    cfg_pid_en = 1'b0;
    for (int i = 0; i < 6; i++) send_pkt(13'(i * 911 + 2), i, 1, 0);
    phase_end("R7 pass all");
    cfg_pid_en = 1'b1;

    // R5: other slice positions and widths
    cfg_pid_ofs = 6'd48; cfg_pid_len = 4'd8;
    for (int i = 0; i < 12; i++) send_pkt(13'(i * 397), i + 3, 1, 0);
    cfg_pid_ofs = 6'd43; cfg_pid_len = 4'd10;
    for (int i = 0; i < 12; i++) send_pkt(13'(i * 523 + 9), i + 5, 1, 0);
    phase_end("R5 slice variants");
    cfg_pid_ofs = 6'd40; cfg_pid_len = 4'd13;

    // R9: strobe gaps at several positions, including the decision cycle
    cfg_pid_en = 1'b0;
    send_pkt(13'd10, 1, 1, 5);
    send_pkt(13'd11, 2, 1, 0);
    send_pkt(13'd12, 3, 1, 8);
    send_pkt(13'd13, 4, 1, 9);
    send_pkt(13'd14, 5, 1, 100);
    send_pkt(13'd15, 6, 1, 0);
    phase_end("R9 gap handling");
    chk(err_count == 16'(exp_err), "R9 err_count", err_count, exp_err);
    cfg_pid_en = 1'b1;

    // R3: misses interrupted by a good sync keep lock
    for (int i = 0; i < 5; i++) send_pkt(13'd0, 0, 0, 0);
    send_pkt(13'd21, 1, 1, 0);
    for (int i = 0; i < 8; i++) send_pkt(13'd0, 0, 0, 0);
    idle(2);
    chk(locked == 1, "R3 lock kept after 8 misses", locked, 1);
    send_pkt(13'd0, 0, 0, 0);
    idle(2);
    chk(locked == 0, "R3 lock lost at 9th miss", locked, 0);
    cfg_pid_en = 1'b0;
    for (int i = 0; i < 3; i++) send_pkt(13'(40 + i), i, 1, 0);
    phase_end("R3 nothing forwarded after loss");
    chk(locked == 0, "R3 still hunting", locked, 0);
    chk(err_count == 16'(exp_err), "R9 err_count final", err_count, exp_err);

    finish_run();
  end
endmodule